// File: doc/BRIEF.md
# Arithmetic Right Shift Unit

This block shifts a 16-bit destination operand one place to the right while keeping its sign. It works on the whole word or on the low byte only. In word mode the sign bit stays in place and is also copied one place down, so the result equals the signed operand divided by two, rounded toward negative infinity. In byte mode only the low byte is shifted, and its bit 7 is the sign that is kept.

When the destination is a register, byte mode writes zeros into the upper byte. When the destination is not a register, the upper byte passes through unchanged.

The unit also updates a status word. Carry takes the bit that falls off the bottom. Negative and zero describe the result at the selected width. Overflow is always cleared. Every other status bit, including the mode and power-control bits, leaves the unit as it came in. A sequencer presents the operand, the size select, the destination kind and the current status together with a one-cycle valid strobe. One clock later it takes the result, the updated status and a register write enable.

Top module: `ars_unit`

## Requirements
- R1: In word mode, result bit 15 equals operand bit 15, result bit 14 also equals operand bit 15, and result bit i equals operand bit i+1 for i from 0 to 13.
- R2: In byte mode, result bits 7..0 are the low byte shifted the same way (bit 7 kept, and copied into bit 6). Result bits 15..8 are zero when in_reg_dst is 1 and equal operand bits 15..8 when in_reg_dst is 0.
- R3: Status bit 0 (carry) takes operand bit 0.
- R4: Status bit 2 (negative) equals result bit 15 in word mode and result bit 7 in byte mode.
- R5: Status bit 1 (zero) is set exactly when the result is zero: all 16 bits in word mode, bits 7..0 only in byte mode.
- R6: Status bit 8 (overflow) is always cleared by an operation.
- R7: Every status bit other than bits 0, 1, 2 and 8 is copied unchanged from in_status.
- R8: Result and status update on the clock edge that samples in_valid high and hold their values while in_valid is low. out_wr_en is high for exactly the cycle after a strobe with in_reg_dst = 1, and low otherwise.
- R9: A synchronous active-high reset clears out_result, out_status and out_wr_en to zero.
- R10: At the selected width, the result equals the signed operand divided by two, rounded toward negative infinity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe, one cycle per operation |
| in_byte | input | 1 | 1 = byte mode, 0 = word mode |
| in_reg_dst | input | 1 | 1 = destination is a register |
| in_operand | input | 16 | Destination operand value |
| in_status | input | 16 | Current status word |
| out_result | output | 16 | Registered shifted result |
| out_wr_en | output | 1 | Register write enable, one cycle |
| out_status | output | 16 | Registered updated status word |

## Verification
The bench builds the unit with its default 16-bit word and 8-bit byte. At these sizes the word-mode sweep covers every one of the 65536 operands. Every low byte is also shifted in byte mode with both destination kinds and changing upper bytes. Each sweep drives a different status word pattern, so the pass-through and flag bits meet all their combinations. Expected results come from floor division and plain bit arithmetic, not from shifts. Hold cycles with changing inputs, and a reset in the middle of the run, exercise the timing of the outputs.

// File: rtl/ars_pkg.sv
package ars_pkg;
  typedef struct packed {
    logic neg;
    logic zero;
    logic carry;
  } ars_flags_t;
endpackage

// File: rtl/ars_shift_lane.sv
module ars_shift_lane #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [DATA_W-1:0] operand,
  input  logic              byte_mode,
  input  logic              reg_dst,
  output logic [DATA_W-1:0] shifted
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    logic word_bit;
    logic byte_bit;
    if (i == DATA_W - 1) begin : g_wtop
      assign word_bit = operand[i];
    end else begin : g_wmid
      assign word_bit = operand[i+1];
    end
    if (i == BYTE_W - 1) begin : g_btop
      assign byte_bit = operand[i];
    end else if (i < BYTE_W - 1) begin : g_bmid
      assign byte_bit = operand[i+1];
    end else begin : g_bup
      assign byte_bit = reg_dst ? 1'b0 : operand[i];
    end
    assign shifted[i] = byte_mode ? byte_bit : word_bit;
  end
endmodule

// File: rtl/ars_flag_gen.sv
module ars_flag_gen
  import ars_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [DATA_W-1:0] shifted,
  input  logic              lsb_out,
  input  logic              byte_mode,
  output ars_flags_t        flags
);
  logic zero_word, zero_byte;
  assign zero_word = ~|shifted;
  assign zero_byte = ~|shifted[BYTE_W-1:0];

  always_comb begin
    flags.carry = lsb_out;
    flags.zero  = byte_mode ? zero_byte : zero_word;
    flags.neg   = byte_mode ? shifted[BYTE_W-1] : shifted[DATA_W-1];
  end
endmodule

// File: rtl/ars_status_merge.sv
module ars_status_merge
  import ars_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int C_BIT  = 0,
  parameter int Z_BIT  = 1,
  parameter int N_BIT  = 2,
  parameter int V_BIT  = 8
) (
  input  logic [DATA_W-1:0] status_in,
  input  ars_flags_t        flags,
  output logic [DATA_W-1:0] status_out
);
  always_comb begin
    status_out        = status_in;
    status_out[C_BIT] = flags.carry;
    status_out[Z_BIT] = flags.zero;
    status_out[N_BIT] = flags.neg;
    status_out[V_BIT] = 1'b0;
  end
endmodule

// File: rtl/ars_unit.sv
module ars_unit
  import ars_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int C_BIT  = 0,
  parameter int Z_BIT  = 1,
  parameter int N_BIT  = 2,
  parameter int V_BIT  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_byte,
  input  logic              in_reg_dst,
  input  logic [DATA_W-1:0] in_operand,
  input  logic [DATA_W-1:0] in_status,
  output logic [DATA_W-1:0] out_result,
  output logic              out_wr_en,
  output logic [DATA_W-1:0] out_status
);
  logic [DATA_W-1:0] shifted_c;
  logic [DATA_W-1:0] status_c;
  ars_flags_t        flags_c;

  ars_shift_lane #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_lane (
    .operand   (in_operand),
    .byte_mode (in_byte),
    .reg_dst   (in_reg_dst),
    .shifted   (shifted_c)
  );

  ars_flag_gen #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_flags (
    .shifted   (shifted_c),
    .lsb_out   (in_operand[0]),
    .byte_mode (in_byte),
    .flags     (flags_c)
  );

  ars_status_merge #(
    .DATA_W(DATA_W), .C_BIT(C_BIT), .Z_BIT(Z_BIT), .N_BIT(N_BIT), .V_BIT(V_BIT)
  ) u_merge (
    .status_in  (in_status),
    .flags      (flags_c),
    .status_out (status_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_result <= '0;
      out_status <= '0;
      out_wr_en  <= 1'b0;
    end else begin
      out_wr_en <= in_valid & in_reg_dst;
      if (in_valid) begin
        out_result <= shifted_c;
        out_status <= status_c;
      end
    end
  end
endmodule

// File: rtl/ars_unit_chk.sv
module ars_unit_chk #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int C_BIT  = 0,
  parameter int Z_BIT  = 1,
  parameter int N_BIT  = 2,
  parameter int V_BIT  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_byte,
  input logic              in_reg_dst,
  input logic [DATA_W-1:0] in_operand,
  input logic [DATA_W-1:0] in_status,
  input logic [DATA_W-1:0] out_result,
  input logic              out_wr_en,
  input logic [DATA_W-1:0] out_status
);
  localparam logic [DATA_W-1:0] FLAG_MASK =
    (DATA_W'(1) << C_BIT) | (DATA_W'(1) << Z_BIT) |
    (DATA_W'(1) << N_BIT) | (DATA_W'(1) << V_BIT);

  assert_word_sign_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid && !in_byte |=> out_result[DATA_W-1] == $past(in_operand[DATA_W-1]) &&
                             out_result[DATA_W-2] == $past(in_operand[DATA_W-1]));

  assert_byte_upper_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_byte && in_reg_dst |=> out_result[DATA_W-1:BYTE_W] == '0);

  assert_carry_R3: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_status[C_BIT] == $past(in_operand[0]));

  assert_negative_R4: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_status[N_BIT] ==
      ($past(in_byte) ? out_result[BYTE_W-1] : out_result[DATA_W-1]));

  assert_zero_R5: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_status[Z_BIT] ==
      ($past(in_byte) ? (out_result[BYTE_W-1:0] == '0) : (out_result == '0)));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> !out_status[V_BIT]);

  assert_passthru_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_status & ~FLAG_MASK) == ($past(in_status) & ~FLAG_MASK));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_result) && $stable(out_status) && !out_wr_en);

  assert_wr_en_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_wr_en == $past(in_reg_dst));

  assert_reset_R9: assert property (@(posedge clk)
    rst |=> out_result == '0 && out_status == '0 && !out_wr_en);
endmodule

bind ars_unit ars_unit_chk #(
  .DATA_W(DATA_W), .BYTE_W(BYTE_W), .C_BIT(C_BIT),
  .Z_BIT(Z_BIT), .N_BIT(N_BIT), .V_BIT(V_BIT)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
  .in_reg_dst(in_reg_dst), .in_operand(in_operand), .in_status(in_status),
  .out_result(out_result), .out_wr_en(out_wr_en), .out_status(out_status)
);

// File: tb/sim_ars_unit.sv
`timescale 1ns/1ps
module sim_ars_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_byte = 1'b0;
  logic        in_reg_dst = 1'b0;
  logic [15:0] in_operand = '0;
  logic [15:0] in_status = '0;
  logic [15:0] out_result;
  logic        out_wr_en;
  logic [15:0] out_status;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  ars_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .in_reg_dst(in_reg_dst), .in_operand(in_operand), .in_status(in_status),
    .out_result(out_result), .out_wr_en(out_wr_en), .out_status(out_status)
  );

  task automatic chk(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic int floor_half(int s);
    if (s < 0 && (s % 2) != 0) return (s - 1) / 2;
    return s / 2;
  endfunction

  task automatic step(logic [15:0] op, logic byt, logic rd, logic [15:0] st);
    int s, q;
    logic [15:0] exp_res, exp_st;
    logic n, z;
    @(negedge clk);
    in_valid = 1'b1; in_byte = byt; in_reg_dst = rd;
    in_operand = op; in_status = st;
    @(posedge clk);
    #1;
    if (!byt) begin
      s = int'($signed(op));
      q = floor_half(s);
      exp_res = 16'(q);
      n = q < 0;
      z = q == 0;
      chk("R10 word value", int'(out_result), int'(exp_res));
      chk("R1 word bits", int'(out_result[15:14]), op[15] ? 3 : 0);
    end else begin
      s = int'($signed(op[7:0]));
      q = floor_half(s);
      exp_res = {rd ? 8'h00 : op[15:8], 8'(q)};
      n = q < 0;
      z = q == 0;
      chk("R2 byte value", int'(out_result), int'(exp_res));
    end
    exp_st = st;
    exp_st[0] = op[0];
    exp_st[1] = z;
    exp_st[2] = n;
    exp_st[8] = 1'b0;
    chk("R3 carry", int'(out_status[0]), int'(op[0]));
    chk("R4 negative", int'(out_status[2]), int'(n));
    chk("R5 zero", int'(out_status[1]), int'(z));
    chk("R6 overflow", int'(out_status[8]), 0);
    chk("R7 status word", int'(out_status), int'(exp_st));
    chk("R8 wr_en", int'(out_wr_en), int'(rd));
  endtask

  initial begin
    #(20 * 190000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] hr, hs;
    repeat (3) @(negedge clk);
    chk("R9 reset result", int'(out_result), 0);
    chk("R9 reset status", int'(out_status), 0);
    chk("R9 reset wr_en", int'(out_wr_en), 0);
    rst = 1'b0;

    // Word sweep over every operand
    for (int i = 0; i < 65536; i++)
      step(16'(i), 1'b0, i[0] ^ i[5], 16'(i * 40503) ^ 16'h0107);

    // Byte sweep: every low byte, both destination kinds, varying upper byte
    for (int rd = 0; rd < 2; rd++)
      for (int i = 0; i < 256; i++)
        step({8'(i * 29 + rd * 77), 8'(i)}, 1'b1, rd[0], 16'(i * 331) ^ 16'hFEF8);

    // Corner cases
    step(16'h8000, 1'b0, 1'b1, 16'hFFFF);
    step(16'hFFFF, 1'b0, 1'b1, 16'h0000);
    step(16'h0001, 1'b0, 1'b0, 16'h0100);
    step(16'hAB80, 1'b1, 1'b1, 16'hFFFF);
    step(16'hCD01, 1'b1, 1'b0, 16'h0000);

    // R8 hold: strobe low while inputs change
    @(negedge clk);
    in_valid = 1'b0;
    hr = out_result; hs = out_status;
    for (int k = 0; k < 4; k++) begin
      in_operand = 16'(k * 4099 + 3); in_status = 16'(k * 911); in_byte = k[0];
      in_reg_dst = 1'b1;
      @(negedge clk);
      chk("R8 hold result", int'(out_result), int'(hr));
      chk("R8 hold status", int'(out_status), int'(hs));
      chk("R8 wr_en idle", int'(out_wr_en), 0);
    end

    // R9 mid-run reset
    step(16'h7FFE, 1'b0, 1'b1, 16'h5A5A);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    chk("R9 mid reset result", int'(out_result), 0);
    chk("R9 mid reset status", int'(out_status), 0);
    chk("R9 mid reset wr_en", int'(out_wr_en), 0);
    rst = 1'b0;
    step(16'h0002, 1'b0, 1'b1, 16'h0000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule